// File: doc/BRIEF.md
# Gated Asynchronous Character Transmitter

This block takes characters from a host one at a time and sends each one on a serial line. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The host sets the frame format, the baud factor and the gating controls through static inputs. It writes a character with a one-cycle strobe while the holding buffer is free. The bit timing comes from a one-cycle strobe, `txClkFall`, which marks each falling edge of the transmit clock. Each serial bit lasts 1, 16 or 64 of these strobes, depending on the baud factor.

The block keeps one character in a holding buffer while the shifter sends the previous one. It moves the held character into the shifter only at a frame boundary, and only while both transmit enable and clear-to-send are active. Two ready indications go back to the host. The status form shows only that the buffer is free. The pin form also requires the two gating inputs. A separate empty flag shows that the shifter has nothing left to send. A break request holds the line low for as long as it is present. It overrides whatever the shifter is sending.

Top module: `char_tx_gated`

## Requirements
- R1: After reset, `txd` is 1, `txRdyStat` is 1, `txEmpty` is 1, and `txRdyPin` is 0 while `txEnable` is 0.
- R2: A frame is a start bit of 0 followed by data bits LSB first. Each bit, the start bit included, holds for exactly F `txClkFall` strobes. F is 1 for `baudSel`=00, 16 for `baudSel`=01 and 64 for `baudSel`=1x. Line changes follow the strobe.
- R3: `dataBits` values 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. Bits of `wrData` above the selected length are never sent.
- R4: With `parityEn`=1, one parity bit follows the data. With `parityOdd`=0 the data bits and the parity bit hold an even number of ones; with `parityOdd`=1 they hold an odd number.
- R5: `twoStop`=0 ends the frame with one stop bit of 1, and `twoStop`=1 ends it with two.
- R6: `txRdyStat` is 1 exactly when the holding buffer is empty. A `wrStrobe` accepted while it is 1 drives it to 0. A `wrStrobe` made while the buffer is full is ignored, and the held character is then sent unchanged.
- R7: `txRdyPin` equals `txRdyStat` AND `txEnable` AND `clearToSend`.
- R8: A held character starts a frame only on a strobe at a frame boundary while `txEnable`=1 and `clearToSend`=1. Until then `txd` stays at 1.
- R9: When a character is waiting and gating is active at the end of the last stop bit, the next start bit begins on the very next strobe, with no idle bit between frames.
- R10: `txEmpty` is 1 whenever the shifter is idle. It is 0 from the start bit until the centre of the final stop bit. With no character waiting, it rises once the final stop bit has passed its centre: after (F-1)/2 rounded down strobes remain, which is the whole bit when F=1.
- R11: While `sendBreak`=1, `txd` is 0. When it returns to 0, the line shows the shifter's level again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txClkFall | input | 1 | One-cycle strobe per transmit-clock falling edge |
| baudSel | input | 2 | Baud factor: 00 = 1x, 01 = 16x, 1x = 64x |
| dataBits | input | 2 | Data length minus 5 |
| parityEn | input | 1 | Append parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | 1 = two stop bits |
| txEnable | input | 1 | Transmit enable command bit |
| clearToSend | input | 1 | Clear-to-send, active high |
| sendBreak | input | 1 | Force line low |
| wrStrobe | input | 1 | Host write strobe |
| wrData | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| txRdyStat | output | 1 | Holding buffer empty |
| txRdyPin | output | 1 | Buffer empty and transmission allowed |
| txEmpty | output | 1 | Shifter idle or past the centre of the final stop bit |

## Verification
The hardest case to reach is the handover between frames. A second character must land in the buffer while the first is still on the line, so the next start bit can follow the last stop bit with no gap. The bench gets there by running the frame checker and a writer in parallel. The writer waits for the status ready flag to come back after the first load, then writes at once. The checker counts the strobes between frames. The same run covers the empty flag, which must stay low through the last stop bit because a character is waiting.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } phase_e;

  typedef struct packed {
    logic   load;
    logic   shift;
    phase_e phase;
  } seq_strb_t;
endpackage

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import sctx_pkg::*;
#(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] baudSel,
  input  logic [1:0] dataBits,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       txEnable,
  input  logic       clearToSend,
  input  logic       bufFull,
  output seq_strb_t  strb,
  output logic       txEmpty
);
  localparam int CNT_W = HI_LOG2;
  localparam logic [CNT_W-1:0] MID_M1 = CNT_W'((1 << MID_LOG2) - 1);
  localparam logic [CNT_W-1:0] HI_M1  = CNT_W'((1 << HI_LOG2) - 1);

  phase_e           phase;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] factorM1;
  logic [CNT_W-1:0] halfThr;
  logic [2:0]       bitIdx;
  logic             canLoad, lastData, finalStop, bitDone, atBoundary;

  always_comb begin
    case (baudSel)
      2'b00:   factorM1 = '0;
      2'b01:   factorM1 = MID_M1;
      default: factorM1 = HI_M1;
    endcase
  end

  assign halfThr    = factorM1 >> 1;
  assign canLoad    = bufFull & txEnable & clearToSend;
  assign lastData   = (bitIdx == (3'd4 + {1'b0, dataBits}));
  assign finalStop  = !twoStop || (bitIdx == 3'd1);
  assign bitDone    = (phase != PH_IDLE) && (tickCnt == '0);
  assign atBoundary = (phase == PH_IDLE) || (phase == PH_STOP && bitDone && finalStop);

  assign strb.load  = tick && canLoad && atBoundary;
  assign strb.shift = tick && (phase == PH_DATA) && bitDone;
  assign strb.phase = phase;

  assign txEmpty = (phase == PH_IDLE) ||
                   (phase == PH_STOP && finalStop && tickCnt <= halfThr && !bufFull);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      if (phase == PH_IDLE) begin
        if (canLoad) begin
          phase   <= PH_START;
          tickCnt <= factorM1;
        end
      end else if (tickCnt != '0) begin
        tickCnt <= tickCnt - 1'b1;
      end else begin
        tickCnt <= factorM1;
        case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitIdx <= '0;
          end
          PH_DATA: begin
            if (lastData) begin
              phase  <= parityEn ? PH_PAR : PH_STOP;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          PH_PAR: begin
            phase  <= PH_STOP;
            bitIdx <= '0;
          end
          default: begin
            if (!finalStop)   bitIdx <= 3'd1;
            else if (canLoad) phase  <= PH_START;
            else              phase  <= PH_IDLE;
          end
        endcase
      end
    end
  end

  // R2: the sequence only moves on a transmit-clock strobe
  assert_hold_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R8: a load always opens a frame with the start bit
  assert_load_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (phase == PH_START));
endmodule

// File: rtl/tx_buf_dp.sv
module tx_buf_dp
  import sctx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        dataBits,
  input  logic              parityOdd,
  input  logic              sendBreak,
  input  seq_strb_t         strb,
  output logic              bufFull,
  output logic              txd
);
  logic [WORD_W-1:0] holdData;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] mask;
  logic              parBit;
  logic              lineBit;

  always_comb begin
    for (int i = 0; i < WORD_W; i++)
      mask[i] = (i < (32'(dataBits) + MIN_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdData <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
      bufFull  <= 1'b0;
    end else begin
      if (strb.load) begin
        shiftReg <= holdData;
        parBit   <= (^(holdData & mask)) ^ parityOdd;
        bufFull  <= 1'b0;
      end else begin
        if (strb.shift) shiftReg <= shiftReg >> 1;
        if (wrStrobe && !bufFull) begin
          holdData <= wrData;
          bufFull  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (strb.phase)
      PH_START: lineBit = 1'b0;
      PH_DATA:  lineBit = shiftReg[0];
      PH_PAR:   lineBit = parBit;
      default:  lineBit = 1'b1;
    endcase
  end

  assign txd = sendBreak ? 1'b0 : lineBit;

  // R6: a full buffer keeps its character until the shifter takes it
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bufFull && !strb.load) |=> $stable(holdData));

  // R8: the control never loads from an empty buffer
  assert_load_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> bufFull);
endmodule

// File: rtl/char_tx_gated.sv
module char_tx_gated
  import sctx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txClkFall,
  input  logic [1:0]        baudSel,
  input  logic [1:0]        dataBits,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              txEnable,
  input  logic              clearToSend,
  input  logic              sendBreak,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wrData,
  output logic              txd,
  output logic              txRdyStat,
  output logic              txRdyPin,
  output logic              txEmpty
);
  seq_strb_t strb;
  logic      bufFull;

  tx_seq_ctrl #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(txClkFall), .baudSel(baudSel),
    .dataBits(dataBits), .parityEn(parityEn), .twoStop(twoStop),
    .txEnable(txEnable), .clearToSend(clearToSend), .bufFull(bufFull),
    .strb(strb), .txEmpty(txEmpty)
  );

  tx_buf_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrData(wrData),
    .dataBits(dataBits), .parityOdd(parityOdd), .sendBreak(sendBreak),
    .strb(strb), .bufFull(bufFull), .txd(txd)
  );

  assign txRdyStat = ~bufFull;
  assign txRdyPin  = ~bufFull & txEnable & clearToSend;

  // R11: a break request owns the line
  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sendBreak |-> !txd);

  // R1: an empty shifter rests at the marking level
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (txEmpty && !sendBreak) |-> txd);
endmodule

// File: tb/tb_char_tx_gated.sv
module tb_char_tx_gated;
  localparam int TICK_DIV = 3;
  localparam int WD_LIMIT = 150000;
  localparam int NVEC     = 6;
  // {baudSel[14:13], dataBits[12:11], parityEn[10], parityOdd[9], twoStop[8], data[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'b00, 2'd3, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'b01, 2'd0, 1'b1, 1'b0, 1'b0, 8'h13},
    {2'b01, 2'd2, 1'b1, 1'b1, 1'b1, 8'h6B},
    {2'b10, 2'd1, 1'b0, 1'b0, 1'b1, 8'h2E},
    {2'b11, 2'd3, 1'b1, 1'b1, 1'b0, 8'h80},
    {2'b00, 2'd0, 1'b1, 1'b1, 1'b1, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txClkFall = 1'b0;
  logic [1:0] baudSel = 2'b00;
  logic [1:0] dataBits = 2'd3;
  logic parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic txEnable = 1'b0, clearToSend = 1'b0, sendBreak = 1'b0;
  logic wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic txd, txRdyStat, txRdyPin, txEmpty;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  int divCnt  = 0;

  char_tx_gated dut (
    .clk(clk), .rst_n(rst_n), .txClkFall(txClkFall), .baudSel(baudSel),
    .dataBits(dataBits), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .txEnable(txEnable), .clearToSend(clearToSend),
    .sendBreak(sendBreak), .wrStrobe(wrStrobe), .wrData(wrData),
    .txd(txd), .txRdyStat(txRdyStat), .txRdyPin(txRdyPin), .txEmpty(txEmpty)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    txClkFall = (divCnt == TICK_DIV - 1);
    divCnt = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tickWait();
    do @(posedge clk); while (!txClkFall);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk);
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  function automatic int factorOf(input logic [1:0] b);
    return (b == 2'b00) ? 1 : (b == 2'b01) ? 16 : 64;
  endfunction

  task automatic expectFrame(input logic [7:0] d, input int nb, input bit pe,
                             input bit po, input bit two, input int f,
                             input bit lastAlone, output int waited);
    bit bitVal [12];
    int nTot, bad, emptyBad;
    bit par;
    bit expE;
    nTot = 0;
    par  = po;
    bitVal[nTot++] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bitVal[nTot++] = d[i];
      par ^= d[i];
    end
    if (pe) bitVal[nTot++] = par;
    bitVal[nTot++] = 1'b1;
    if (two) bitVal[nTot++] = 1'b1;
    waited = 0;
    do begin
      tickWait();
      waited++;
    end while (txd !== 1'b0 && waited < 3000);
    bad = 0;
    emptyBad = 0;
    for (int b = 0; b < nTot; b++) begin
      for (int k = 0; k < f; k++) begin
        if (!(b == 0 && k == 0)) tickWait();
        if (txd !== bitVal[b]) bad++;
        expE = lastAlone && (b == nTot - 1) && ((f - 1 - k) <= ((f - 1) >> 1));
        if (txEmpty !== expE) emptyBad++;
      end
    end
    chk(bad == 0, "R2/R3/R4/R5 frame bit mismatches", bad, 0);
    chk(emptyBad == 0, "R10 txEmpty mismatches in frame", emptyBad, 0);
  endtask

  initial begin
    int w1, w2, highBad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(txRdyStat === 1'b1, "R1 txRdyStat after reset", txRdyStat, 1);
    chk(txEmpty === 1'b1, "R1 txEmpty after reset", txEmpty, 1);
    chk(txRdyPin === 1'b0, "R1 txRdyPin after reset", txRdyPin, 0);

    // R7 pin gating with an empty buffer
    for (int c = 0; c < 4; c++) begin
      txEnable = c[0];
      clearToSend = c[1];
      @(negedge clk);
      chk(txRdyPin === (c[0] & c[1]), "R7 txRdyPin gating", txRdyPin, c[0] & c[1]);
    end

    // R6 / R8: hold while disabled, second write ignored, CTS gating
    txEnable = 1'b0; clearToSend = 1'b1;
    baudSel = 2'b00; dataBits = 2'd3; parityEn = 1'b0; twoStop = 1'b0;
    hostWrite(8'hA5);
    chk(txRdyStat === 1'b0, "R6 txRdyStat after write", txRdyStat, 0);
    chk(txRdyPin === 1'b0, "R7 txRdyPin with buffer full", txRdyPin, 0);
    hostWrite(8'h3C);
    highBad = 0;
    for (int i = 0; i < 10; i++) begin
      tickWait();
      if (txd !== 1'b1) highBad++;
    end
    chk(highBad == 0, "R8 line stays marking without enable", highBad, 0);
    txEnable = 1'b1; clearToSend = 1'b0;
    highBad = 0;
    for (int i = 0; i < 10; i++) begin
      tickWait();
      if (txd !== 1'b1) highBad++;
    end
    chk(highBad == 0, "R8 line stays marking without CTS", highBad, 0);
    chk(txEmpty === 1'b1, "R10 txEmpty while shifter idle", txEmpty, 1);
    clearToSend = 1'b1;
    expectFrame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1, 1'b1, w1);
    chk(txRdyPin === 1'b1, "R7 txRdyPin after load", txRdyPin, 1);

    // vector table: R2, R3, R4, R5, R10
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      baudSel   = VEC[v][14:13];
      dataBits  = VEC[v][12:11];
      parityEn  = VEC[v][10];
      parityOdd = VEC[v][9];
      twoStop   = VEC[v][8];
      hostWrite(VEC[v][7:0]);
      expectFrame(VEC[v][7:0], 5 + int'(VEC[v][12:11]), VEC[v][10], VEC[v][9],
                  VEC[v][8], factorOf(VEC[v][14:13]), 1'b1, w1);
      tickWait();
      chk(txd === 1'b1 && txEmpty === 1'b1, "R10 idle after frame",
          {txd, txEmpty}, 3);
    end

    // R9 back-to-back frames
    @(negedge clk);
    baudSel = 2'b01; dataBits = 2'd2; parityEn = 1'b1; parityOdd = 1'b0; twoStop = 1'b1;
    hostWrite(8'h4D);
    fork
      expectFrame(8'h4D, 7, 1'b1, 1'b0, 1'b1, 16, 1'b0, w1);
      begin
        while (txRdyStat !== 1'b1) @(negedge clk);
        hostWrite(8'h32);
      end
    join
    expectFrame(8'h32, 7, 1'b1, 1'b0, 1'b1, 16, 1'b1, w2);
    chk(w2 == 1, "R9 gap between frames in strobes", w2, 1);

    // R11 break while idle
    tickWait();
    sendBreak = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R11 break forces low", txd, 0);
    for (int i = 0; i < 5; i++) tickWait();
    chk(txd === 1'b0, "R11 break holds low", txd, 0);
    sendBreak = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R11 line returns after break", txd, 1);

    // R11 break during a frame of all-ones data
    baudSel = 2'b00; dataBits = 2'd3; parityEn = 1'b0; twoStop = 1'b0;
    hostWrite(8'hFF);
    w1 = 0;
    do begin tickWait(); w1++; end while (txd !== 1'b0 && w1 < 100);
    tickWait();
    tickWait();
    chk(txd === 1'b1, "R11 data bit before break", txd, 1);
    sendBreak = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R11 break overrides data", txd, 0);
    sendBreak = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R11 data resumes after break", txd, 1);
    for (int i = 0; i < 12; i++) tickWait();
    chk(txd === 1'b1 && txEmpty === 1'b1, "R10 idle after break frame", {txd, txEmpty}, 3);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule